// File: doc/BRIEF.md
# Ring-Sampled Random Number Register Controller

This block is a memory-mapped controller that gathers raw entropy bits into a bank of 32-bit result words. Software uses one control word to pick an entropy source out of four oscillator inputs and an output length of two, four, six or eight words. It then sets the enable bit and the start bit. A separate period register sets how many clocks pass between two entropy samples.

While start is set, the block takes one bit from the chosen source at every period boundary. It packs the bits into words, least significant bit first, and writes each finished word into the bank. When the last word of the requested length is written, start clears itself. Software polls start until it reads 0 and then reads the words. Control writes are bit-masked: the upper half of the write data says which of the lower bits the write may change. A write that clears the low half with a full mask stops a run at once.

In this design the oscillators are not built. They appear as the input port `entropy_in`, one bit for each source.

Top module: `rng_ring_ctrl`

## Requirements
- R1: After reset, the control word at byte offset 0x400, the period register at 0x404 and all eight result words read 0.
- R2: A write to 0x400 changes control bit i (i = 0..5) only where write bit 16+i is 1, and then takes the value of write bit i. The control word reads back as bit 0 start, bit 1 enable, bits [3:2] source, bits [5:4] length, and 0 in every other bit.
- R3: A write that sets start with its mask bit begins a new run only if enable is 1 after the same write. Otherwise start reads 0 and no result word changes.
- R4: The period register at 0x404 holds bits [15:0] of the write data and reads them back. During a run, sample number k (k = 0, 1, ...) is taken at clock edge E0 + P*(k+1). E0 is the edge that accepted the start, and P is the register value, or 1 when the value is 0.
- R5: Control bits [3:2] = s choose bit s of `entropy_in` as the sampled source.
- R6: Control bits [5:4] = L request 2*(L+1) words. Bit b of result word w is sample number 32*w + b.
- R7: Start reads 1 until the edge that takes the final sample. It reads 0 from that edge on.
- R8: A run does not change result words at index 2*(L+1) or above. They keep their earlier contents.
- R9: A write of 0x0000 to the low control half with mask 0xFFFF clears start and enable. It stops the run, so no further result word is written.
- R10: Result word i reads at byte offset 0x410 + 4*i for i = 0..7. Unaligned offsets and offsets not listed here read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_addr | input | 12 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data: control value in bits [15:0], write mask in bits [31:16] |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| entropy_in | input | 4 | Raw entropy bits, one for each oscillator source |

## Verification
A start write accepted at edge E0 with effective period P and N sampled bits has its k-th sample due at edge E0 + P*(k+1). Start is due to fall at edge E0 + P*N. The bench counts rising edges and reads start at the falling edge before and the falling edge after edge E0 + P*N. It sets each source input at a falling edge to a hash of the number of the next edge, so the value of every sample can be predicted. Read data is combinational, so the bench checks register and result words half a cycle after a write edge.

// File: rtl/rng_pkg.sv
// Package: shared offsets and the control word layout of the ring-sampled
// random number controller. Assumes a byte-addressed, word-aligned register map.
package rng_pkg;
    localparam int unsigned CTRL_OFS  = 32'h400;
    localparam int unsigned PER_OFS   = 32'h404;
    localparam int unsigned WORD_BASE = 32'h410;
    localparam int unsigned OSC_W     = 2;
    localparam int unsigned NOSC      = 1 << OSC_W;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CTRL_W    = 6;
    localparam int unsigned MASK_LSB  = 16;

    // Control word bits [5:0]: len[5:4], osc[3:2], en[1], start[0]
    typedef struct packed {
        logic [1:0]       len;
        logic [OSC_W-1:0] osc;
        logic             en;
        logic             start;
    } ctrl_t;
endpackage

// File: rtl/rng_ctrl_regs.sv
// Control and period registers. Applies write-masked control updates,
// gates start with enable and self-clears start when the sampler is done.
// Assumes that done_i is a single-cycle pulse from the sampler.
module rng_ctrl_regs
    import rng_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_per_i,
    input  logic [CTRL_W-1:0] data_i,
    input  logic [CTRL_W-1:0] mask_i,
    input  logic [PER_W-1:0]  per_data_i,
    input  logic              done_i,
    output ctrl_t             ctrl_o,
    output logic [PER_W-1:0]  per_o,
    output logic              restart_o
);
    ctrl_t ctrl_q;
    ctrl_t merged;
    ctrl_t ctrl_d;
    logic [PER_W-1:0] per_q;

    // Merge the masked write data and force start low without enable
    always_comb begin
        merged = ctrl_t'((ctrl_q & ~mask_i) | (data_i & mask_i));
        merged.start = merged.start & merged.en;
        restart_o = wr_ctrl_i && mask_i[0] && data_i[0] && merged.en;
        ctrl_d = ctrl_q;
        if (wr_ctrl_i) begin
            ctrl_d = merged;
        end
        if (done_i && !restart_o) begin
            ctrl_d.start = 1'b0;
        end
    end

    // Control register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // Sample period register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
        end else if (wr_per_i) begin
            per_q <= per_data_i;
        end
    end

    assign ctrl_o = ctrl_q;
    assign per_o  = per_q;

    // R3: a start request with enable low afterwards leaves start low
    assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && !ctrl_q.en && !(mask_i[1] && data_i[1])) |=> !ctrl_q.start);

    // R9: clearing enable through a masked write idles the unit
    assert_halt_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_i && mask_i[1] && !data_i[1]) |=> (!ctrl_q.start && !ctrl_q.en));
endmodule

// File: rtl/rng_sampler.sv
// Sampling counter and word assembler. While busy, takes one entropy bit
// per period from the selected source, packs bits LSB first and issues a
// word write every 32 samples; pulses done with the last requested word.
// Assumes busy_i is the start bit and restart_i marks an accepted start.
module rng_sampler
    import rng_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int NWORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              restart_i,
    input  logic [OSC_W-1:0]  osc_i,
    input  logic [1:0]        len_i,
    input  logic [PER_W-1:0]  per_i,
    input  logic [NOSC-1:0]   entropy_i,
    output logic              wr_o,
    output logic [$clog2(NWORDS)-1:0] wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              done_o
);
    localparam int IDX_W = $clog2(NWORDS);
    localparam int BIT_W = $clog2(DATA_W);

    logic [PER_W-1:0]  cnt_q;
    logic [PER_W-1:0]  per_eff;
    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  word_q;
    logic [DATA_W-1:0] asm_q;
    logic [IDX_W-1:0]  last_idx;
    logic              fire;
    logic              samp;

    // Effective period, last word index and sample strobe
    always_comb begin
        per_eff  = (per_i == '0) ? PER_W'(1) : per_i;
        last_idx = IDX_W'({len_i, 1'b1});
        fire     = busy_i && !restart_i && (cnt_q >= per_eff - PER_W'(1));
        samp     = entropy_i[osc_i];
    end

    // Period counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !busy_i) begin
            cnt_q <= '0;
        end else if (fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

    // Bit and word position, plus assembly register
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !busy_i) begin
            bit_q  <= '0;
            word_q <= '0;
            asm_q  <= '0;
        end else if (fire) begin
            asm_q[bit_q] <= samp;
            bit_q        <= bit_q + BIT_W'(1);
            if (bit_q == BIT_W'(DATA_W - 1)) begin
                word_q <= word_q + IDX_W'(1);
            end
        end
    end

    assign wr_o      = fire && (bit_q == BIT_W'(DATA_W - 1));
    assign wr_idx_o  = word_q;
    assign wr_data_o = {samp, asm_q[DATA_W-2:0]};
    assign done_o    = wr_o && (word_q == last_idx);

    // R6: word writes stay inside the requested length
    assert_word_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> (wr_idx_o <= last_idx));

    // R7: the final word drops the busy flag on the next cycle
    assert_done_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_i);
endmodule

// File: rtl/rng_word_bank.sv
// Result word storage: one 32-bit register per word, written by index,
// read combinationally. Assumes at most one write per cycle.
module rng_word_bank
    import rng_pkg::*;
#(
    parameter int NWORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [$clog2(NWORDS)-1:0] wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [$clog2(NWORDS)-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int IDX_W = $clog2(NWORDS);

    logic [DATA_W-1:0] mem_q [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        // Word register i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wr_i && (wr_idx_i == IDX_W'(i))) begin
                mem_q[i] <= wr_data_i;
            end
        end

        // R8: a word not addressed by a write keeps its contents
        assert_word_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && (wr_idx_i == IDX_W'(i))) |=> $stable(mem_q[i]));
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/rng_ring_ctrl.sv
// Top of the ring-sampled random number controller: address decode,
// read mux, control registers, sampler and result bank.
// Assumes word-aligned accesses; unmapped reads return zero.
module rng_ring_ctrl
    import rng_pkg::*;
#(
    parameter int NWORDS = 8,
    parameter int PER_W  = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NOSC-1:0]   entropy_in
);
    localparam int IDX_W = $clog2(NWORDS);

    logic              sel_ctrl;
    logic              sel_per;
    logic              sel_word;
    logic [ADDR_W-1:0] woff;
    ctrl_t             ctrl;
    logic [PER_W-1:0]  per;
    logic              restart;
    logic              wr_w;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic              done;
    logic [DATA_W-1:0] word_rd;
    logic              unused_wdata;

    // Address decode
    always_comb begin
        woff     = bus_addr - ADDR_W'(WORD_BASE);
        sel_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
        sel_per  = (bus_addr == ADDR_W'(PER_OFS));
        sel_word = (bus_addr >= ADDR_W'(WORD_BASE)) &&
                   (woff < ADDR_W'(4 * NWORDS)) && (woff[1:0] == 2'b00);
    end

    assign unused_wdata = ^bus_wdata[31:MASK_LSB+CTRL_W];

    rng_ctrl_regs #(.PER_W(PER_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl_i  (bus_wr && sel_ctrl),
        .wr_per_i   (bus_wr && sel_per),
        .data_i     (bus_wdata[CTRL_W-1:0]),
        .mask_i     (bus_wdata[MASK_LSB+CTRL_W-1:MASK_LSB]),
        .per_data_i (bus_wdata[PER_W-1:0]),
        .done_i     (done),
        .ctrl_o     (ctrl),
        .per_o      (per),
        .restart_o  (restart)
    );

    rng_sampler #(.PER_W(PER_W), .NWORDS(NWORDS)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (ctrl.start),
        .restart_i (restart),
        .osc_i     (ctrl.osc),
        .len_i     (ctrl.len),
        .per_i     (per),
        .entropy_i (entropy_in),
        .wr_o      (wr_w),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .done_o    (done)
    );

    rng_word_bank #(.NWORDS(NWORDS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_w),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (woff[IDX_W+1:2]),
        .rd_data_o (word_rd)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata = 32'(ctrl);
        end else if (sel_per) begin
            bus_rdata = 32'(per);
        end else if (sel_word) begin
            bus_rdata = word_rd;
        end
    end

    // R10: unmapped offsets read zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ctrl && !sel_per && !sel_word) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/rng_ring_ctrl_tb.sv
`timescale 1ns/1ps
module rng_ring_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  entropy_in = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 1'b0;
    logic [31:0] shadow [8];

    typedef struct packed { int len; int osc; int per; int cycles; } vec_t;
    localparam vec_t VEC [6] = '{
        '{3, 0, 1,   256},
        '{0, 1, 0,    64},
        '{1, 2, 3,   384},
        '{2, 3, 5,   960},
        '{0, 0, 100, 6400},
        '{1, 3, 2,   256}
    };

    rng_ring_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entropy_in(entropy_in)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic ent(int n, int j);
        logic [31:0] h;
        h = 32'(n) * 32'h9E3779B1;
        return h[j*5+7];
    endfunction

    // Drive each source with a hash of the edge number that will sample it
    always @(negedge clk) begin
        logic [3:0] v;
        for (int j = 0; j < 4; j++) v[j] = ent(cyc + 1, j);
        entropy_in <= v;
    end

    function automatic logic [31:0] exp_word(int e0, int p, int osc, int w);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) r[b] = ent(e0 + p * (w * 32 + b + 1), osc);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, output int edge_n);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; edge_n = cyc + 1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic check_words(input int e0, input int p, input int len, input int osc, input string tag);
        logic [31:0] rd;
        logic [31:0] ex;
        for (int w = 0; w < 8; w++) begin
            bus_read(12'h410 + 12'(4 * w), rd);
            if (w < 2 * (len + 1)) begin
                ex = exp_word(e0, p, osc, w);
                chk(tag, rd, ex);
                shadow[w] = ex;
            end else begin
                chk("R8 untouched word", rd, shadow[w]);
            end
        end
    endtask

    initial begin
        int e0;
        int dummy;
        int p;
        logic [31:0] rd;
        for (int w = 0; w < 8; w++) shadow[w] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(12'h400, rd); chk("R1 ctrl reset", rd, 32'h0);
        bus_read(12'h404, rd); chk("R1 period reset", rd, 32'h0);
        bus_read(12'h410, rd); chk("R1 word0 reset", rd, 32'h0);
        bus_read(12'h42C, rd); chk("R1 word7 reset", rd, 32'h0);
        // R10 unmapped and unaligned
        bus_read(12'h408, rd); chk("R10 unmapped 0x408", rd, 32'h0);
        bus_read(12'h430, rd); chk("R10 past last word", rd, 32'h0);
        bus_read(12'h411, rd); chk("R10 unaligned", rd, 32'h0);

        // R2 masked writes
        bus_write(12'h400, 32'h0000_003E, dummy);
        bus_read(12'h400, rd); chk("R2 zero mask ignored", rd, 32'h0);
        bus_write(12'h400, 32'h000C_FFF8, dummy);
        bus_read(12'h400, rd); chk("R2 osc field only", rd, 32'h0000_0008);
        bus_write(12'h400, 32'h0008_0000, dummy);
        bus_read(12'h400, rd); chk("R2 clear osc bit", rd, 32'h0);

        // R4 period readback
        bus_write(12'h404, 32'hFFFF_1234, dummy);
        bus_read(12'h404, rd); chk("R4 period readback", rd, 32'h0000_1234);
        bus_write(12'h404, 32'h0, dummy);

        // R3 start without enable is ignored
        bus_write(12'h400, 32'h0001_0001, e0);
        bus_read(12'h400, rd); chk("R3 start needs enable", rd, 32'h0);
        wait_cyc(e0 + 100);
        bus_read(12'h410, rd); chk("R3 no word written", rd, 32'h0);

        // Vector table: R4 R5 R6 R7 R8
        for (int i = 0; i < 6; i++) begin
            p = (VEC[i].per == 0) ? 1 : VEC[i].per;
            bus_write(12'h404, 32'(VEC[i].per), dummy);
            bus_write(12'h400, 32'h003F_0003 | 32'(VEC[i].len << 4) | 32'(VEC[i].osc << 2), e0);
            wait_cyc(e0 + VEC[i].cycles - 1);
            bus_read(12'h400, rd); chk("R7 start high before last sample", {31'h0, rd[0]}, 32'h1);
            @(negedge clk);
            bus_read(12'h400, rd);
            chk("R7 start cleared on last sample", rd,
                32'(VEC[i].len << 4) | 32'(VEC[i].osc << 2) | 32'h2);
            check_words(e0, p, VEC[i].len, VEC[i].osc, "R6 R5 R4 word value");
        end

        // R3 enable already set, start alone
        bus_write(12'h404, 32'd2, dummy);
        bus_write(12'h400, 32'h003E_0006, dummy);
        bus_write(12'h400, 32'h0001_0001, e0);
        bus_read(12'h400, rd); chk("R3 start with prior enable", rd, 32'h0000_0007);
        wait_cyc(e0 + 128);
        bus_read(12'h400, rd); chk("R7 short run done", rd, 32'h0000_0006);
        check_words(e0, 2, 0, 1, "R3 word value");

        // R9 halt mid run
        bus_write(12'h404, 32'd50, dummy);
        bus_write(12'h400, 32'h003F_0033, e0);
        wait_cyc(e0 + 200);
        bus_write(12'h400, 32'hFFFF_0000, dummy);
        bus_read(12'h400, rd); chk("R9 halt idles unit", rd, 32'h0);
        wait_cyc(e0 + 2000);
        for (int w = 0; w < 2; w++) begin
            bus_read(12'h410 + 12'(4 * w), rd);
            chk("R9 no word after halt", rd, shadow[w]);
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule